// File: doc/BRIEF.md
# Resumable Non-Maskable Interrupt Trap Controller

This block adds a second trap level above the ordinary machine-mode trap path of a small hart. A non-maskable request line is sampled every cycle. When it is taken, the block records the address of the interrupted instruction, a cause code and the privilege the hart was running at. It then sends fetch to a fixed handler address for non-maskable interrupts. While that handler runs, a further request stays pending and does not nest. An exception raised inside the handler goes to its own vector and is reported through the machine-mode capture port. A return strobe ends the handler, sends fetch back to the saved address and restores the saved privilege.

Four CSRs belong to this trap level: a scratch word, a saved PC, a cause and a status word. The core's CSR stage reads and writes them through a plain request port. Reads are combinational. Writes take effect at the next clock edge and are refused below machine privilege. Every redirect is a registered pulse that lasts one cycle. That cycle is the core's flush slot, and the arbiter takes no new event during it. No path here has back-pressure: the core must act on a redirect in the cycle it appears, and the CSR port never stalls.

Top module: `nmi_trap_ctrl`

## Requirements
- R1: After reset the privilege is machine (2'b11), the handler flag is clear, no redirect or capture is signalled and all four CSRs read zero.
- R2: A taken request gives, one cycle later, a redirect pulse to parameter NMI_IRQ_VEC. It also sets the handler flag, sets machine privilege and stores the current PC with bit 0 cleared in the saved-PC register.
- R3: Outside the handler, and when no redirect is showing, the non-maskable request wins over an exception or interrupt raised in the same cycle. The block has no enable input that masks it.
- R4: The cause register is loaded with 3 when the bus-error source flag is high on entry, and with parameter NMI_EXT_CAUSE otherwise.
- R5: On entry the status register stores the previous privilege in bits 12:11. All its other bits read zero, so an entry from machine mode reads 0x00001800.
- R6: While the handler flag is set, a request is held off. The flag stays set until a return is taken.
- R7: An exception inside the handler redirects to parameter NMI_EXC_VEC. It pulses the capture port with the exception cause and the current PC and leaves the four CSRs and the handler flag unchanged.
- R8: Outside the handler, an exception (first) or an interrupt redirects to parameter MTVEC, sets machine privilege and pulses the capture port. Interrupts are ignored inside the handler.
- R9: A return strobe inside the handler redirects to the saved PC, sets the privilege to status bits 12:11 and clears the flag. Outside the handler the strobe is ignored. An exception in the same cycle wins over the strobe.
- R10: CSR addresses are 0x350 scratch, 0x351 saved PC, 0x352 cause and 0x353 status. Writes at machine privilege store all bits, except that bit 0 of the saved PC is forced to zero and only bits 12:11 of status are kept. Other addresses read zero.
- R11: A valid access to 0x350 to 0x353 below machine privilege raises the illegal output in the same cycle and changes no register.
- R12: A redirect lasts exactly one cycle. Any event raised during it is ignored, and a level request is taken afterwards. A CSR write in a cycle where a trap or return is taken is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| nmi_req_i | input | 1 | Non-maskable request, level |
| nmi_buserr_i | input | 1 | Request comes from the bus-error source |
| exc_req_i | input | 1 | Exception at current instruction |
| exc_cause_i | input | XLEN | Exception cause |
| irq_req_i | input | 1 | Ordinary interrupt request |
| irq_cause_i | input | XLEN | Interrupt cause |
| cur_pc_i | input | XLEN | Address of current instruction |
| ret_i | input | 1 | Return-from-handler strobe |
| csr_valid_i | input | 1 | CSR access valid |
| csr_we_i | input | 1 | CSR access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data |
| csr_illegal_o | output | 1 | Access refused, illegal instruction |
| redirect_valid_o | output | 1 | One-cycle fetch redirect |
| redirect_pc_o | output | XLEN | Redirect target |
| priv_o | output | 2 | Current privilege |
| in_nmi_o | output | 1 | Handler flag |
| mcap_valid_o | output | 1 | Machine trap capture strobe |
| mcap_cause_o | output | XLEN | Cause for machine cause register |
| mcap_epc_o | output | XLEN | PC for machine epc register |

## Verification
The assertions check on every cycle that the redirect is a single-cycle pulse and that a request outside the handler wins the arbiter. They also check that the handler flag holds until a return, that a return restores the stored privilege, that the saved PC is always even and that a refused access leaves the registers untouched. Only the bench's scenarios can show the cause codes and redirect targets for each kind of event and the pending request being taken after the return. The same holds for the CSR masking rules and the privilege drop that makes accesses illegal, which the bench reaches through random status writes.

// File: rtl/nmi_trap_pkg.sv
package nmi_trap_pkg;
  localparam logic [1:0] PRIV_M = 2'b11;
  localparam logic [9:0] CSR_BLOCK = 10'h0D4; // 0x350..0x353
  localparam int PP_LO = 11;

  typedef enum logic [2:0] {
    TK_NONE, TK_NMI, TK_EXC, TK_IRQ, TK_RET
  } trap_kind_e;
endpackage

// File: rtl/nmi_trap_arb.sv
module nmi_trap_arb
  import nmi_trap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       in_nmi_i,
  input  logic       nmi_req_i,
  input  logic       exc_req_i,
  input  logic       irq_req_i,
  input  logic       ret_i,
  output trap_kind_e kind_o
);
  always_comb begin
    kind_o = TK_NONE;
    if (!busy_i) begin
      if (in_nmi_i) begin
        if (exc_req_i)  kind_o = TK_EXC;
        else if (ret_i) kind_o = TK_RET;
      end else begin
        if (nmi_req_i)      kind_o = TK_NMI;
        else if (exc_req_i) kind_o = TK_EXC;
        else if (irq_req_i) kind_o = TK_IRQ;
      end
    end
  end

  // R3: the request is never beaten by another event outside the handler
  a_r3_nmi_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_req_i && !in_nmi_i && !busy_i) |-> kind_o == TK_NMI);
  // R12: nothing is taken while a redirect is showing
  a_r12_flush_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> kind_o == TK_NONE);
endmodule

// File: rtl/nmi_csr_file.sv
module nmi_csr_file
  import nmi_trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      priv_i,
  input  logic            hold_i,
  input  logic            entry_i,
  input  logic [XLEN-1:0] entry_pc_i,
  input  logic [XLEN-1:0] entry_cause_i,
  input  logic            csr_valid_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_illegal_o,
  output logic [XLEN-1:0] epc_o,
  output logic [1:0]      mpp_o
);
  logic [XLEN-1:0] scratch_q, epc_q, cause_q;
  logic [1:0]      mpp_q;
  logic            hit, wr;

  assign hit           = csr_addr_i[11:2] == CSR_BLOCK;
  assign csr_illegal_o = csr_valid_i && hit && (priv_i != PRIV_M);
  assign wr            = csr_valid_i && csr_we_i && hit && (priv_i == PRIV_M) && !hold_i;

  always_comb begin
    csr_rdata_o = '0;
    if (hit) begin
      case (csr_addr_i[1:0])
        2'd0: csr_rdata_o = scratch_q;
        2'd1: csr_rdata_o = epc_q;
        2'd2: csr_rdata_o = cause_q;
        default: csr_rdata_o[PP_LO+1:PP_LO] = mpp_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
      mpp_q     <= '0;
    end else if (entry_i) begin
      epc_q   <= {entry_pc_i[XLEN-1:1], 1'b0};
      cause_q <= entry_cause_i;
      mpp_q   <= priv_i;
    end else if (wr) begin
      case (csr_addr_i[1:0])
        2'd0: scratch_q <= csr_wdata_i;
        2'd1: epc_q     <= {csr_wdata_i[XLEN-1:1], 1'b0};
        2'd2: cause_q   <= csr_wdata_i;
        default: mpp_q  <= csr_wdata_i[PP_LO+1:PP_LO];
      endcase
    end
  end

  assign epc_o = epc_q;
  assign mpp_o = mpp_q;

  // R10: saved PC stays even
  a_r10_epc_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epc_q[0] == 1'b0);
  // R11: a refused access changes nothing
  a_r11_illegal_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_illegal_o && !entry_i) |=> ($stable(scratch_q) && $stable(epc_q)
                                     && $stable(cause_q) && $stable(mpp_q)));
  // R5: entry records the prior privilege
  a_r5_status_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i |=> mpp_q == $past(priv_i));
endmodule

// File: rtl/nmi_trap_ctrl.sv
module nmi_trap_ctrl
  import nmi_trap_pkg::*;
#(
  parameter int              XLEN          = 32,
  parameter logic [XLEN-1:0] NMI_IRQ_VEC   = 'h0000_0100,
  parameter logic [XLEN-1:0] NMI_EXC_VEC   = 'h0000_0180,
  parameter logic [XLEN-1:0] MTVEC         = 'h0000_0040,
  parameter logic [XLEN-1:0] NMI_EXT_CAUSE = 'h0000_0001
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            nmi_req_i,
  input  logic            nmi_buserr_i,
  input  logic            exc_req_i,
  input  logic [XLEN-1:0] exc_cause_i,
  input  logic            irq_req_i,
  input  logic [XLEN-1:0] irq_cause_i,
  input  logic [XLEN-1:0] cur_pc_i,
  input  logic            ret_i,
  input  logic            csr_valid_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_illegal_o,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [1:0]      priv_o,
  output logic            in_nmi_o,
  output logic            mcap_valid_o,
  output logic [XLEN-1:0] mcap_cause_o,
  output logic [XLEN-1:0] mcap_epc_o
);
  localparam logic [XLEN-1:0] BUSERR_CAUSE = XLEN'(3);

  trap_kind_e      kind;
  logic [1:0]      priv_q, mpp;
  logic            in_nmi_q, redir_q, mcap_q;
  logic [XLEN-1:0] redir_pc_q, mcause_q, mepc_q, saved_epc, entry_cause;

  assign entry_cause = nmi_buserr_i ? BUSERR_CAUSE : NMI_EXT_CAUSE;

  nmi_trap_arb u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (redir_q),
    .in_nmi_i  (in_nmi_q),
    .nmi_req_i (nmi_req_i),
    .exc_req_i (exc_req_i),
    .irq_req_i (irq_req_i),
    .ret_i     (ret_i),
    .kind_o    (kind)
  );

  nmi_csr_file #(.XLEN(XLEN)) u_csr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .priv_i        (priv_q),
    .hold_i        (kind != TK_NONE),
    .entry_i       (kind == TK_NMI),
    .entry_pc_i    (cur_pc_i),
    .entry_cause_i (entry_cause),
    .csr_valid_i   (csr_valid_i),
    .csr_we_i      (csr_we_i),
    .csr_addr_i    (csr_addr_i),
    .csr_wdata_i   (csr_wdata_i),
    .csr_rdata_o   (csr_rdata_o),
    .csr_illegal_o (csr_illegal_o),
    .epc_o         (saved_epc),
    .mpp_o         (mpp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q     <= PRIV_M;
      in_nmi_q   <= 1'b0;
      redir_q    <= 1'b0;
      redir_pc_q <= '0;
      mcap_q     <= 1'b0;
      mcause_q   <= '0;
      mepc_q     <= '0;
    end else begin
      redir_q <= (kind != TK_NONE);
      mcap_q  <= 1'b0;
      case (kind)
        TK_NMI: begin
          in_nmi_q   <= 1'b1;
          priv_q     <= PRIV_M;
          redir_pc_q <= NMI_IRQ_VEC;
        end
        TK_EXC: begin
          priv_q     <= PRIV_M;
          redir_pc_q <= in_nmi_q ? NMI_EXC_VEC : MTVEC;
          mcap_q     <= 1'b1;
          mcause_q   <= exc_cause_i;
          mepc_q     <= cur_pc_i;
        end
        TK_IRQ: begin
          priv_q     <= PRIV_M;
          redir_pc_q <= MTVEC;
          mcap_q     <= 1'b1;
          mcause_q   <= irq_cause_i;
          mepc_q     <= cur_pc_i;
        end
        TK_RET: begin
          in_nmi_q   <= 1'b0;
          priv_q     <= mpp;
          redir_pc_q <= saved_epc;
        end
        default: ;
      endcase
    end
  end

  assign redirect_valid_o = redir_q;
  assign redirect_pc_o    = redir_pc_q;
  assign priv_o           = priv_q;
  assign in_nmi_o         = in_nmi_q;
  assign mcap_valid_o     = mcap_q;
  assign mcap_cause_o     = mcause_q;
  assign mcap_epc_o       = mepc_q;

  // R12: redirect is a single-cycle pulse
  a_r12_redirect_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_q |=> !redir_q);
  // R2: entry lands on the interrupt vector with the flag set
  a_r2_entry_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == TK_NMI) |=> (redir_q && in_nmi_q && redir_pc_q == NMI_IRQ_VEC));
  // R6: no leaving the handler except by return
  a_r6_no_nest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_nmi_q && kind != TK_RET) |=> in_nmi_q);
  // R9: return restores stored privilege and clears the flag
  a_r9_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == TK_RET) |=> (!in_nmi_q && priv_q == $past(mpp)));
endmodule

// File: tb/test_nmi_trap_ctrl.sv
`timescale 1ns/1ps
module test_nmi_trap_ctrl;
  localparam logic [31:0] IRQ_V = 32'h0000_0100;
  localparam logic [31:0] EXC_V = 32'h0000_0180;
  localparam logic [31:0] MTV   = 32'h0000_0040;
  localparam logic [31:0] EXTC  = 32'h0000_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        d_nmi = 0, d_be = 0, d_exc = 0, d_irq = 0, d_ret = 0;
  logic        d_cv = 0, d_cwe = 0;
  logic [31:0] d_ec = 0, d_ic = 0, d_pc = 0, d_cwd = 0;
  logic [11:0] d_ca = 0;

  logic [31:0] csr_rdata_o, redirect_pc_o, mcap_cause_o, mcap_epc_o;
  logic        csr_illegal_o, redirect_valid_o, in_nmi_o, mcap_valid_o;
  logic [1:0]  priv_o;

  nmi_trap_ctrl #(.XLEN(32), .NMI_IRQ_VEC(IRQ_V), .NMI_EXC_VEC(EXC_V),
                  .MTVEC(MTV), .NMI_EXT_CAUSE(EXTC)) i_nmi_trap_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .nmi_req_i(d_nmi), .nmi_buserr_i(d_be),
    .exc_req_i(d_exc), .exc_cause_i(d_ec), .irq_req_i(d_irq), .irq_cause_i(d_ic),
    .cur_pc_i(d_pc), .ret_i(d_ret), .csr_valid_i(d_cv), .csr_we_i(d_cwe),
    .csr_addr_i(d_ca), .csr_wdata_i(d_cwd), .csr_rdata_o(csr_rdata_o),
    .csr_illegal_o(csr_illegal_o), .redirect_valid_o(redirect_valid_o),
    .redirect_pc_o(redirect_pc_o), .priv_o(priv_o), .in_nmi_o(in_nmi_o),
    .mcap_valid_o(mcap_valid_o), .mcap_cause_o(mcap_cause_o), .mcap_epc_o(mcap_epc_o));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic [1:0]  m_priv = 2'b11, m_mpp = 0;
  logic        m_in = 0, m_redir = 0, m_mcv = 0;
  logic [31:0] m_scr = 0, m_epc = 0, m_cause = 0, m_rpc = 0, m_mcc = 0, m_mce = 0;
  string       m_tag = "R12";

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic bit hit(input logic [11:0] a);
    return a[11:2] == 10'h0D4;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (!hit(a)) return 32'h0;
    case (a[1:0])
      2'd0: return m_scr;
      2'd1: return m_epc;
      2'd2: return m_cause;
      default: return {19'h0, m_mpp, 11'h0};
    endcase
  endfunction

  // 0 none, 1 nmi, 2 exc, 3 irq, 4 ret
  function automatic int exp_kind();
    if (m_redir) return 0;
    if (m_in) begin
      if (d_exc) return 2;
      if (d_ret) return 4;
      return 0;
    end
    if (d_nmi) return 1;
    if (d_exc) return 2;
    if (d_irq) return 3;
    return 0;
  endfunction

  task automatic step();
    int k;
    bit wr;
    #1;
    chk("R11 illegal", {31'h0, csr_illegal_o}, {31'h0, d_cv && hit(d_ca) && m_priv != 2'b11});
    chk("R10 rdata", csr_rdata_o, exp_rd(d_ca));
    k  = exp_kind();
    wr = d_cv && d_cwe && hit(d_ca) && m_priv == 2'b11 && k == 0;
    @(posedge clk);
    m_redir = (k != 0);
    m_mcv = 0;
    case (k)
      1: begin
        m_in = 1; m_mpp = m_priv; m_priv = 2'b11; m_rpc = IRQ_V;
        m_epc = {d_pc[31:1], 1'b0}; m_cause = d_be ? 32'd3 : EXTC; m_tag = "R2";
      end
      2: begin
        m_rpc = m_in ? EXC_V : MTV; m_tag = m_in ? "R7" : "R8";
        m_priv = 2'b11; m_mcv = 1; m_mcc = d_ec; m_mce = d_pc;
      end
      3: begin
        m_rpc = MTV; m_priv = 2'b11; m_mcv = 1; m_mcc = d_ic; m_mce = d_pc; m_tag = "R8";
      end
      4: begin
        m_in = 0; m_priv = m_mpp; m_rpc = m_epc; m_tag = "R9";
      end
      default: m_tag = "R12";
    endcase
    if (wr) begin
      case (d_ca[1:0])
        2'd0: m_scr = d_cwd;
        2'd1: m_epc = {d_cwd[31:1], 1'b0};
        2'd2: m_cause = d_cwd;
        default: m_mpp = d_cwd[12:11];
      endcase
    end
    @(negedge clk);
    chk("R12 redirect valid", {31'h0, redirect_valid_o}, {31'h0, m_redir});
    if (m_redir) chk({m_tag, " redirect pc"}, redirect_pc_o, m_rpc);
    chk("R9 privilege", {30'h0, priv_o}, {30'h0, m_priv});
    chk("R6 handler flag", {31'h0, in_nmi_o}, {31'h0, m_in});
    chk("R8 capture valid", {31'h0, mcap_valid_o}, {31'h0, m_mcv});
    if (m_mcv) begin
      chk({m_tag, " capture cause"}, mcap_cause_o, m_mcc);
      chk({m_tag, " capture epc"}, mcap_epc_o, m_mce);
    end
  endtask

  task automatic idle();
    d_nmi = 0; d_be = 0; d_exc = 0; d_irq = 0; d_ret = 0; d_cv = 0; d_cwe = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    d_cv = 1; d_cwe = 0; d_ca = a;
    #1;
    chk(tag, csr_rdata_o, e);
    d_cv = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 redirect", {31'h0, redirect_valid_o}, 32'h0);
    chk("R1 priv", {30'h0, priv_o}, 32'h3);
    chk("R1 flag", {31'h0, in_nmi_o}, 32'h0);
    chk("R1 capture", {31'h0, mcap_valid_o}, 32'h0);
    rd(12'h353, 32'h0, "R1 status");
    rd(12'h350, 32'h0, "R1 scratch");

    // R3 all three events at once, bus-error source
    d_nmi = 1; d_be = 1; d_exc = 1; d_irq = 1; d_pc = 32'h0000_1001;
    step();
    chk("R3 winner target", redirect_pc_o, IRQ_V);
    chk("R3 no capture", {31'h0, mcap_valid_o}, 32'h0);
    idle();
    rd(12'h352, 32'd3, "R4 bus error cause");
    rd(12'h351, 32'h0000_1000, "R2 saved pc");
    rd(12'h353, 32'h0000_1800, "R5 status from machine");

    // R6 held request while in handler
    d_nmi = 1; d_be = 0;
    step(); step();
    chk("R6 no nested redirect", {31'h0, redirect_valid_o}, 32'h0);
    // R7 exception inside handler
    d_nmi = 0; d_exc = 1; d_ec = 32'd2; d_pc = 32'h0000_2000;
    step();
    chk("R7 exc vector", redirect_pc_o, EXC_V);
    chk("R7 capture cause", mcap_cause_o, 32'd2);
    idle(); step();
    rd(12'h351, 32'h0000_1000, "R7 saved pc kept");
    // R9 return with request held, R12 flush cycle
    d_ret = 1; d_nmi = 1;
    step();
    chk("R9 return target", redirect_pc_o, 32'h0000_1000);
    d_ret = 0;
    step();
    chk("R12 flush ignores request", {31'h0, redirect_valid_o}, 32'h0);
    step();
    chk("R6 pending taken after return", redirect_pc_o, IRQ_V);
    idle(); step();
    rd(12'h352, EXTC, "R4 other cause");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      d_nmi = ($urandom % 12) == 0;
      d_be  = $urandom % 2;
      d_exc = ($urandom % 10) == 0;
      d_irq = ($urandom % 8) == 0;
      d_ret = m_in && (($urandom % 5) == 0);
      d_ec  = $urandom % 16;
      d_ic  = 32'h8000_0000 | ($urandom % 16);
      d_pc  = $urandom;
      d_cv  = ($urandom % 3) == 0;
      d_cwe = $urandom % 2;
      d_ca  = 12'h34E + 12'($urandom % 7);
      d_cwd = $urandom;
      step();
    end
    idle();
    done = 1;
    summary();
  end
endmodule